// File: doc/BRIEF.md
# Unimplemented Access and Illegal PIO Detector

This block sits beside the bus and inspects every memory and programmed-I/O (PIO) access. A memory access faults when it falls into one of two enabled holes in the address map. Each hole is set by an inclusive low and high bound. A PIO command faults in two cases: it lies at or past the first unimplemented command for its direction, or it lies in the spare I/O space while spare commands are configured as illegal.

Every fault drives a one-cycle pulse. The address or command of the first fault after an arm is held in a capture register. That register is then frozen until a clear re-arms it, so later faults still pulse but do not overwrite the first failing address.

Top module: `unimpl_access_detector`

## Requirements
- R1: After reset `fault_o` is 0, `fail_addr_o` is 0 and capture is armed.
- R2: A valid access with kind 0 (memory) whose address satisfies lo <= addr <= hi for an enabled hole drives `fault_o` high for the cycle after that access's clock edge. Both bounds are inclusive.
- R3: A disabled hole never faults. A hole whose low bound exceeds its high bound matches no address.
- R4: With the threshold check enabled, a kind 2 (PIO output) command faults when bits 15:6 of the command are >= bits 15:6 of the output threshold. A kind 1 (PIO input) command is compared against the input threshold in the same way. Threshold bits 5:0 have no effect.
- R5: With the threshold check disabled, a non-spare PIO command never faults.
- R6: A PIO command with bits 15:14 = 2'b11 is spare. It faults when spare-legal is 0, whatever the threshold enable. When spare-legal is 1 it never faults.
- R7: While capture is armed, a fault loads the access address into `fail_addr_o` and disarms capture. While capture is disarmed, later faults still pulse `fault_o` and leave `fail_addr_o` unchanged.
- R8: Asserting `cap_clear_i` re-arms capture from the next cycle. A fault in the same cycle as the clear is captured only if capture was already armed.
- R9: No fault is raised when `acc_valid_i` is 0, or for kind 3, which is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Access strobe |
| acc_kind_i | input | 2 | 0 memory, 1 PIO in, 2 PIO out, 3 reserved |
| acc_addr_i | input | 16 | Memory address or PIO command |
| blk1_en_i | input | 1 | Hole 1 enable |
| blk1_lo_i | input | 16 | Hole 1 low bound |
| blk1_hi_i | input | 16 | Hole 1 high bound |
| blk2_en_i | input | 1 | Hole 2 enable |
| blk2_lo_i | input | 16 | Hole 2 low bound |
| blk2_hi_i | input | 16 | Hole 2 high bound |
| pio_chk_en_i | input | 1 | Threshold check enable |
| pio_out_first_i | input | 16 | First unimplemented output command (bits 15:6 used) |
| pio_in_first_i | input | 16 | First unimplemented input command (bits 15:6 used) |
| spare_legal_i | input | 1 | 1 = spare commands legal |
| cap_clear_i | input | 1 | Re-arm capture |
| fault_o | output | 1 | One-cycle fault pulse |
| fail_addr_o | output | 16 | First failing address |

## Verification
The assertions check on every cycle that:
- an inverted hole never matches;
- a legal spare command never faults;
- no pulse follows an idle or reserved cycle;
- the capture register moves only while armed;
- disarming coincides with a pulse.

Inclusive bound edges, the threshold compare ignoring low bits, the clear-and-fault collision and re-capture after clearing depend on chosen stimulus sequences. Only the bench's scenarios, compared each cycle against the behavioural model, can show those.

// File: rtl/uad_pkg.sv
package uad_pkg;
  typedef enum logic [1:0] {
    ACC_MEM     = 2'd0,
    ACC_PIO_IN  = 2'd1,
    ACC_PIO_OUT = 2'd2,
    ACC_RSVD    = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/uad_mem_window.sv
module uad_mem_window #(
  parameter int AW = 16
) (
  input  logic          en_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  assign hit_o = en_i && (addr_i >= lo_i) && (addr_i <= hi_i);

  always_comb begin
    if (lo_i > hi_i) assert_empty_window_R3: assert (!hit_o);
  end
endmodule

// File: rtl/uad_pio_check.sv
module uad_pio_check #(
  parameter int          AW          = 16,
  parameter int          TH_LSB      = 6,
  parameter logic [15:0] SPARE_MASK  = 16'hC000,
  parameter logic [15:0] SPARE_MATCH = 16'hC000
) (
  input  logic          is_out_i,
  input  logic [AW-1:0] cmd_i,
  input  logic [AW-1:0] th_out_i,
  input  logic [AW-1:0] th_in_i,
  input  logic          chk_en_i,
  input  logic          spare_legal_i,
  output logic          illegal_o
);
  localparam int CW = AW - TH_LSB;

  logic [CW-1:0] cmd_hi, th_hi;
  logic          is_spare, past_th;

  assign th_hi    = is_out_i ? th_out_i[AW-1:TH_LSB] : th_in_i[AW-1:TH_LSB];
  assign cmd_hi   = cmd_i[AW-1:TH_LSB];
  assign past_th  = cmd_hi >= th_hi;
  assign is_spare = (cmd_i & SPARE_MASK[AW-1:0]) == SPARE_MATCH[AW-1:0];
  // spare space takes its own legality rule, exempt from thresholds
  assign illegal_o = is_spare ? !spare_legal_i : (chk_en_i && past_th);

  always_comb begin
    if (is_spare && spare_legal_i) assert_spare_legal_R6: assert (!illegal_o);
  end
endmodule

// File: rtl/uad_capture.sv
module uad_capture #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          det_i,
  input  logic [AW-1:0] addr_i,
  input  logic          clear_i,
  output logic          fault_o,
  output logic [AW-1:0] fail_addr_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b1;
      fault_o     <= 1'b0;
      fail_addr_o <= '0;
    end else begin
      fault_o <= det_i;
      if (det_i && armed_q) fail_addr_o <= addr_i;
      if (clear_i)    armed_q <= 1'b1;
      else if (det_i) armed_q <= 1'b0;
    end
  end

  assert_hold_disarmed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(fail_addr_o));
  assert_disarm_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(armed_q) |-> fault_o);
  assert_rearm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> armed_q);
endmodule

// File: rtl/unimpl_access_detector.sv
module unimpl_access_detector
  import uad_pkg::*;
#(
  parameter int AW      = 16,
  parameter int TH_LSB  = 6,
  parameter int NUM_BLK = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_kind_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          blk1_en_i,
  input  logic [AW-1:0] blk1_lo_i,
  input  logic [AW-1:0] blk1_hi_i,
  input  logic          blk2_en_i,
  input  logic [AW-1:0] blk2_lo_i,
  input  logic [AW-1:0] blk2_hi_i,
  input  logic          pio_chk_en_i,
  input  logic [AW-1:0] pio_out_first_i,
  input  logic [AW-1:0] pio_in_first_i,
  input  logic          spare_legal_i,
  input  logic          cap_clear_i,
  output logic          fault_o,
  output logic [AW-1:0] fail_addr_o
);
  logic [NUM_BLK-1:0]         blk_en, blk_hit;
  logic [NUM_BLK-1:0][AW-1:0] blk_lo, blk_hi;
  logic                       pio_bad, is_mem, is_pio, det;
  acc_kind_e                  kind;

  assign blk_en = {blk2_en_i, blk1_en_i};
  assign blk_lo = {blk2_lo_i, blk1_lo_i};
  assign blk_hi = {blk2_hi_i, blk1_hi_i};
  assign kind   = acc_kind_e'(acc_kind_i);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_win
    uad_mem_window #(.AW(AW)) u_win (
      .en_i  (blk_en[g]),
      .lo_i  (blk_lo[g]),
      .hi_i  (blk_hi[g]),
      .addr_i(acc_addr_i),
      .hit_o (blk_hit[g])
    );
  end

  uad_pio_check #(.AW(AW), .TH_LSB(TH_LSB)) u_pio (
    .is_out_i     (kind == ACC_PIO_OUT),
    .cmd_i        (acc_addr_i),
    .th_out_i     (pio_out_first_i),
    .th_in_i      (pio_in_first_i),
    .chk_en_i     (pio_chk_en_i),
    .spare_legal_i(spare_legal_i),
    .illegal_o    (pio_bad)
  );

  assign is_mem = kind == ACC_MEM;
  assign is_pio = (kind == ACC_PIO_IN) || (kind == ACC_PIO_OUT);
  assign det    = acc_valid_i && ((is_mem && |blk_hit) || (is_pio && pio_bad));

  uad_capture #(.AW(AW)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (det),
    .addr_i     (acc_addr_i),
    .clear_i    (cap_clear_i),
    .fault_o    (fault_o),
    .fail_addr_o(fail_addr_o)
  );

  assert_quiet_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_valid_i || acc_kind_i == 2'd3) |=> !fault_o);
endmodule

// File: tb/unimpl_access_detector_test.sv
module unimpl_access_detector_test;
  logic        clk = 0, rst_n = 0;
  logic        valid = 0, b1_en = 0, b2_en = 0, chk_en = 0, sp_ok = 0, clr = 0;
  logic [1:0]  kind = 0;
  logic [15:0] addr = 0, b1_lo = 0, b1_hi = 0, b2_lo = 0, b2_hi = 0, th_out = 0, th_in = 0;
  logic        fault;
  logic [15:0] fail_addr;

  int    checks = 0, errors = 0;
  bit    done = 0, live = 0;
  string cur_req = "R1";

  // reference state
  bit          m_fault = 0, m_armed = 1;
  logic [15:0] m_addr = 0;

  always #2 clk = ~clk;

  unimpl_access_detector uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_kind_i(kind), .acc_addr_i(addr),
    .blk1_en_i(b1_en), .blk1_lo_i(b1_lo), .blk1_hi_i(b1_hi),
    .blk2_en_i(b2_en), .blk2_lo_i(b2_lo), .blk2_hi_i(b2_hi),
    .pio_chk_en_i(chk_en), .pio_out_first_i(th_out), .pio_in_first_i(th_in),
    .spare_legal_i(sp_ok), .cap_clear_i(clr), .fault_o(fault), .fail_addr_o(fail_addr));

  function automatic bit expect_fault();
    int a, t;
    if (!valid) return 0;
    a = addr;
    if (kind == 0)
      return (b1_en && a >= int'(b1_lo) && a <= int'(b1_hi)) ||
             (b2_en && a >= int'(b2_lo) && a <= int'(b2_hi));
    if (kind == 3) return 0;
    if (a / 16384 == 3) return !sp_ok;
    t = (kind == 2) ? int'(th_out) : int'(th_in);
    return chk_en && (a / 64 >= t / 64);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fault = 0; m_armed = 1; m_addr = 0;
    end else begin
      bit f;
      f = expect_fault();
      m_fault = f;
      if (f && m_armed) m_addr = addr;
      if (clr) m_armed = 1; else if (f) m_armed = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    check(cur_req, "fault_o", int'(fault), int'(m_fault));
    check(cur_req, "fail_addr_o", int'(fail_addr), int'(m_addr));
  end

  task automatic acc(input logic [1:0] k, input logic [15:0] a, input bit c = 0);
    @(negedge clk); #1;
    valid = 1; kind = k; addr = a; clr = c;
    @(negedge clk); #1;
    valid = 0; clr = 0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset fault_o", int'(fault), 0);
    check("R1", "reset fail_addr_o", int'(fail_addr), 0);
    #1 rst_n = 1;
    live = 1;
    b1_en = 1; b1_lo = 16'h1000; b1_hi = 16'h1FFF;
    b2_en = 1; b2_lo = 16'h8000; b2_hi = 16'h80FF;
    chk_en = 1; th_out = 16'h0400; th_in = 16'h0800;

    cur_req = "R2";
    acc(0, 16'h0FFF); acc(0, 16'h1000); acc(0, 16'h1FFF); acc(0, 16'h2000);
    cur_req = "R7";
    acc(0, 16'h80FF); acc(0, 16'h8100);
    cur_req = "R8";
    acc(0, 16'h0000, 1); acc(0, 16'h8000);
    acc(0, 16'h1234, 1);   // disarmed at the collision: no capture, re-armed
    acc(0, 16'h1800);

    cur_req = "R4";
    acc(2, 16'h03FF); acc(2, 16'h0400); acc(1, 16'h0400); acc(1, 16'h07FF); acc(1, 16'h0800);
    th_out = 16'h043F;
    acc(2, 16'h0400); acc(2, 16'h03C0);
    cur_req = "R5";
    chk_en = 0;
    acc(2, 16'h0FFF); acc(1, 16'h3FFF);
    cur_req = "R6";
    acc(1, 16'hC000); acc(2, 16'hFFFF);
    chk_en = 1; sp_ok = 1;
    acc(1, 16'hC000); acc(2, 16'hFFC0); acc(2, 16'h8000);

    cur_req = "R3";
    acc(0, 16'h0000, 1);
    b2_en = 0;
    acc(0, 16'h8010);
    b1_lo = 16'h3000; b1_hi = 16'h2000;
    acc(0, 16'h2800); acc(0, 16'h3000);
    b1_lo = 16'h4000; b1_hi = 16'h4000;
    acc(0, 16'h4000); acc(0, 16'h4001);

    cur_req = "R9";
    acc(0, 16'h0000, 1);
    @(negedge clk); #1; valid = 0; kind = 0; addr = 16'h4000;
    @(negedge clk); #1; valid = 1; kind = 3; addr = 16'hFFFF;
    @(negedge clk); #1; valid = 0;
    acc(0, 16'h4000);
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule